// File: doc/BRIEF.md
# Octet Stress Pattern Generator and Checker

This block sends one of four fixed, repeating octet stress patterns as a serial bit stream and checks the same pattern on a receive bit stream. Long runs of dense octets are followed by long runs of empty octets, so the patterns exercise a line's clock recovery and density handling in a way a pseudo-random sequence does not. A two-bit mode input selects the pattern for both the transmitter and the checker. A clock enable paces both sides at the line bit rate.

The checker hunts for a two-octet window that fits exactly one phase of the selected pattern. It then confirms the lock over a run of good octets before it raises a sync flag. While in sync it counts every mismatched bit in a saturating counter and watches a sliding window of recent octets to decide when lock is lost. An inject input flips one transmitted bit per pulse, so a loopback can prove the error path.

Top module: `octet_stress_pat`

## Requirements
- R1: With mode 0, the transmitter repeats a 200-octet cycle: octets 0 to 99 are 0xFF and octets 100 to 199 are 0x00. Octets go out most-significant bit first, starting from octet 0 after reset.
- R2: With mode 1, the 200-octet cycle is 0x7E for octets 0 to 99 and 0x00 for octets 100 to 199.
- R3: With mode 2, every octet is 0x4C, sent as 0,1,0,0,1,1,0,0.
- R4: With mode 3, the cycle is 55 octets long. All octets are 0x00 except octet 6, which is 0x80.
- R5: tx_bit changes only at a clock edge where bit_en is high, and then by one bit. A change of mode restarts the cycle at the most-significant bit of octet 0.
- R6: Each inject pulse inverts exactly one transmitted bit. That bit is the one sent at the first bit_en edge at or after the pulse.
- R7: The checker searches for lock by comparing the last 16 received bits with every pair of consecutive pattern octets. It accepts only a window that matches exactly one pair. It raises in_sync after 8 further consecutive error-free octets, and an errored octet before that sends it back to the search.
- R8: While in_sync is high, the checker drops sync when 4 of the last 16 completed octets held an error. It keeps sync with 3.
- R9: err_count rises by one for each received bit that differs from the expected bit, but only while in_sync is high. A change of mode drops sync at once.
- R10: err_count saturates at its all-ones value.
- R11: err_clear zeroes err_count at the next edge. It takes priority over a bit error counted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate clock enable, one bit per high cycle |
| mode | input | 2 | Pattern select: 0 0xFF/0x00, 1 0x7E/0x00, 2 0x4C, 3 sparse 55-octet |
| inject | input | 1 | Flip the next transmitted bit |
| tx_bit | output | 1 | Serial transmit bit |
| rx_bit | input | 1 | Serial receive bit |
| err_clear | input | 1 | Synchronous clear of the error counter |
| in_sync | output | 1 | Checker is locked to the pattern |
| err_count | output | ERR_W | Saturating count of received bit errors |

## Verification
The clear input and a counted bit error can land on the same edge. The bench provokes this in a loopback by flipping the line bit in the very cycle it raises err_clear, and then expects a zero count. A single further flip must then read as one. A second overlap is an inject pulse that coincides with a bit_en edge, which must flip that same bit. The scoreboard judges this from the expected bit stream, and the error counter must show the flip one bit later.

// File: rtl/osp_pkg.sv
package osp_pkg;

  localparam logic [7:0] OCT_FULL  = 8'hFF;
  localparam logic [7:0] OCT_FLAG  = 8'h7E;
  localparam logic [7:0] OCT_MID   = 8'h4C;
  localparam logic [7:0] OCT_MARK  = 8'h80;
  localparam logic [7:0] OCT_EMPTY = 8'h00;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } rx_state_e;

  // Octet at position idx of the pattern selected by mode.
  function automatic logic [7:0] pat_octet(input logic [1:0] mode, input int idx,
                                           input int half, input int mark);
    case (mode)
      2'd0:    return (idx < half) ? OCT_FULL : OCT_EMPTY;
      2'd1:    return (idx < half) ? OCT_FLAG : OCT_EMPTY;
      2'd2:    return OCT_MID;
      default: return (idx == mark) ? OCT_MARK : OCT_EMPTY;
    endcase
  endfunction

  function automatic int pat_len(input logic [1:0] mode, input int half, input int lone_len);
    case (mode)
      2'd0, 2'd1: return 2 * half;
      2'd2:       return 1;
      default:    return lone_len;
    endcase
  endfunction

endpackage

// File: rtl/osp_tx.sv
module osp_tx import osp_pkg::*; #(
  parameter int HALF      = 100,
  parameter int LONE_LEN  = 55,
  parameter int LONE_MARK = 6,
  parameter int IDX_W     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] mode,
  input  logic       inject,
  output logic       tx_bit
);

  logic [1:0]       mode_q;
  logic [IDX_W-1:0] idx_q, idx_c;
  logic [2:0]       bcnt_q, bcnt_c;
  logic             pend_q, tx_q, chg, bit_c;
  logic [7:0]       oct_c;
  int               len_c;

  always_comb begin
    chg    = (mode != mode_q);
    idx_c  = chg ? '0 : idx_q;
    bcnt_c = chg ? 3'd0 : bcnt_q;
    len_c  = pat_len(mode, HALF, LONE_LEN);
    oct_c  = pat_octet(mode, int'(idx_c), HALF, LONE_MARK);
    bit_c  = oct_c[3'd7 - bcnt_c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode;
      idx_q  <= '0;
      bcnt_q <= 3'd0;
      pend_q <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      mode_q <= mode;
      if (bit_en) begin
        tx_q   <= bit_c ^ (pend_q | inject);
        pend_q <= 1'b0;
        bcnt_q <= bcnt_c + 3'd1;
        if (bcnt_c == 3'd7)
          idx_q <= (int'(idx_c) == len_c - 1) ? '0 : idx_c + 1'b1;
        else
          idx_q <= idx_c;
      end else begin
        pend_q <= pend_q | inject;
        idx_q  <= idx_c;
        bcnt_q <= bcnt_c;
      end
    end
  end

  assign tx_bit = tx_q;

  // R5: no enable, no new bit
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit));

  // R5: octet position stays inside the cycle of the mode it was counted for
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < pat_len(mode_q, HALF, LONE_LEN));

endmodule

// File: rtl/osp_err_cnt.sv
module osp_err_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc && cnt_q != '1)
      cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (count == '1 && !clr) |=> count == '1);

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);

  assert_step_one_R9: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/osp_rx.sv
module osp_rx import osp_pkg::*; #(
  parameter int HALF      = 100,
  parameter int LONE_LEN  = 55,
  parameter int LONE_MARK = 6,
  parameter int MAX_LEN   = 200,
  parameter int IDX_W     = 8,
  parameter int SYNC_GOOD = 8,
  parameter int LOSS_BAD  = 4,
  parameter int LOSS_WIN  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] mode,
  input  logic       rx_bit,
  output logic       in_sync,
  output logic       err_inc
);

  localparam int GOOD_W = $clog2(SYNC_GOOD + 1);

  rx_state_e            st_q;
  logic [1:0]           mode_q;
  logic [15:0]          win_q, win_n;
  logic [IDX_W-1:0]     idx_q, idx_nx;
  logic [2:0]           bcnt_q;
  logic                 bad_acc_q;
  logic [GOOD_W-1:0]    good_q;
  logic [LOSS_WIN-1:0]  hist_q, hist_n;
  logic [7:0]           exp_oct;
  logic                 exp_bit, mis, oct_done, oct_bad, chg;
  int                   len_c, hits, hit_p, bad_cnt;

  always_comb begin
    chg   = (mode != mode_q);
    len_c = pat_len(mode, HALF, LONE_LEN);
    win_n = {win_q[14:0], rx_bit};
    hits  = 0;
    hit_p = 0;
    for (int p = 0; p < MAX_LEN; p++) begin
      if (p < len_c) begin
        if (pat_octet(mode, (p == 0) ? len_c - 1 : p - 1, HALF, LONE_MARK) == win_n[15:8] &&
            pat_octet(mode, p, HALF, LONE_MARK) == win_n[7:0]) begin
          hits++;
          hit_p = p;
        end
      end
    end
    exp_oct  = pat_octet(mode, int'(idx_q), HALF, LONE_MARK);
    exp_bit  = exp_oct[3'd7 - bcnt_q];
    mis      = rx_bit ^ exp_bit;
    oct_done = (bcnt_q == 3'd7);
    oct_bad  = bad_acc_q | mis;
    idx_nx   = (int'(idx_q) == len_c - 1) ? '0 : idx_q + 1'b1;
    hist_n   = {hist_q[LOSS_WIN-2:0], oct_bad};
    bad_cnt  = 0;
    for (int i = 0; i < LOSS_WIN; i++)
      if (hist_n[i]) bad_cnt++;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      mode_q    <= mode;
      win_q     <= '0;
      idx_q     <= '0;
      bcnt_q    <= 3'd0;
      bad_acc_q <= 1'b0;
      good_q    <= '0;
      hist_q    <= '0;
    end else begin
      mode_q <= mode;
      if (chg) begin
        st_q      <= ST_HUNT;
        idx_q     <= '0;
        bcnt_q    <= 3'd0;
        bad_acc_q <= 1'b0;
      end else if (bit_en) begin
        win_q <= win_n;
        if (st_q == ST_HUNT) begin
          if (hits == 1) begin
            st_q      <= ST_VERIFY;
            idx_q     <= IDX_W'((hit_p == len_c - 1) ? 0 : hit_p + 1);
            bcnt_q    <= 3'd0;
            bad_acc_q <= 1'b0;
            good_q    <= '0;
          end
        end else begin
          bcnt_q    <= bcnt_q + 3'd1;
          bad_acc_q <= oct_done ? 1'b0 : oct_bad;
          if (oct_done) begin
            idx_q <= idx_nx;
            if (st_q == ST_VERIFY) begin
              if (oct_bad)
                st_q <= ST_HUNT;
              else if (good_q == GOOD_W'(SYNC_GOOD - 1)) begin
                st_q   <= ST_SYNC;
                hist_q <= '0;
              end else
                good_q <= good_q + 1'b1;
            end else begin
              hist_q <= hist_n;
              if (bad_cnt >= LOSS_BAD)
                st_q <= ST_HUNT;
            end
          end
        end
      end
    end
  end

  assign in_sync = (st_q == ST_SYNC);
  assign err_inc = (st_q == ST_SYNC) && bit_en && !chg && mis;

  // R9: a new mode always throws the checker back to the search
  assert_mode_drop_R9: assert property (@(posedge clk) disable iff (rst)
    chg |=> !in_sync);

  // R7: sync is only entered from the confirmation phase
  assert_enter_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_sync && st_q != ST_VERIFY) |=> !in_sync);

  // R8: an octet that completes with a clean window never loses sync
  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (in_sync && bit_en && !chg && oct_done && hist_n == '0) |=> in_sync);

endmodule

// File: rtl/octet_stress_pat.sv
module octet_stress_pat #(
  parameter int HALF      = 100,
  parameter int LONE_LEN  = 55,
  parameter int LONE_MARK = 6,
  parameter int SYNC_GOOD = 8,
  parameter int LOSS_BAD  = 4,
  parameter int LOSS_WIN  = 16,
  parameter int ERR_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [1:0]       mode,
  input  logic             inject,
  output logic             tx_bit,
  input  logic             rx_bit,
  input  logic             err_clear,
  output logic             in_sync,
  output logic [ERR_W-1:0] err_count
);

  localparam int MAX_LEN = (2 * HALF > LONE_LEN) ? 2 * HALF : LONE_LEN;
  localparam int IDX_W   = $clog2(MAX_LEN);

  logic err_inc;

  osp_tx #(.HALF(HALF), .LONE_LEN(LONE_LEN), .LONE_MARK(LONE_MARK), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode), .inject(inject), .tx_bit(tx_bit)
  );

  osp_rx #(.HALF(HALF), .LONE_LEN(LONE_LEN), .LONE_MARK(LONE_MARK), .MAX_LEN(MAX_LEN),
           .IDX_W(IDX_W), .SYNC_GOOD(SYNC_GOOD), .LOSS_BAD(LOSS_BAD), .LOSS_WIN(LOSS_WIN)) u_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode), .rx_bit(rx_bit),
    .in_sync(in_sync), .err_inc(err_inc)
  );

  osp_err_cnt #(.W(ERR_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(err_clear), .inc(err_inc), .count(err_count)
  );

  // R9: without sync the error count cannot move except by a clear
  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_sync && !err_clear) |=> $stable(err_count));

endmodule

// File: tb/sim_octet_stress_pat.sv
module sim_octet_stress_pat;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 3;

  logic clk = 1'b0;
  logic rst, bit_en, inject, err_clear, line_flip;
  logic [1:0] mode;
  logic tx_bit, rx_bit, in_sync;
  logic [ERR_W-1:0] err_count;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign rx_bit = tx_bit ^ line_flip;

  octet_stress_pat #(.ERR_W(ERR_W)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode), .inject(inject),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .err_clear(err_clear),
    .in_sync(in_sync), .err_count(err_count)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic exp_q[$];
  string tag_q[$];
  logic [1:0] m_mode;
  int m_idx, m_bc;
  logic m_pend, en_d, last_tx, exp_b;
  string exp_t;

  function automatic logic [7:0] model_oct(input logic [1:0] m, input int i);
    if (m == 2'd2) return 8'b0100_1100;
    if (m == 2'd3) return (i == 6) ? 8'b1000_0000 : 8'b0;
    if (i >= 100) return 8'b0;
    return (m == 2'd0) ? 8'b1111_1111 : 8'b0111_1110;
  endfunction

  function automatic int model_len(input logic [1:0] m);
    return (m == 2'd2) ? 1 : (m == 2'd3) ? 55 : 200;
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compare every emitted bit, and hold between enables (R5)
  always @(posedge clk) en_d <= bit_en & ~rst;
  always @(negedge clk) begin
    if (en_d) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 queue empty", 0, 1);
      else begin
        exp_b = exp_q.pop_front();
        exp_t = tag_q.pop_front();
        chk(tx_bit === exp_b, exp_t, int'(tx_bit), int'(exp_b));
      end
    end else if (!rst) begin
      chk(tx_bit === last_tx, "R5 hold", int'(tx_bit), int'(last_tx));
    end
    last_tx = tx_bit;
  end

  // Driver: applies one cycle of stimulus and pushes the expected bit
  task automatic step(input logic en, input logic inj, input logic flip, input logic clr);
    logic [7:0] o;
    @(negedge clk);
    bit_en = en; inject = inj; line_flip = flip; err_clear = clr;
    if (en) begin
      o = model_oct(m_mode, m_idx);
      exp_q.push_back(o[7 - m_bc] ^ (inj | m_pend));
      tag_q.push_back((inj | m_pend) ? "R6" : tag_of(m_mode));
      m_pend = 1'b0;
      if (m_bc == 7) begin
        m_bc = 0;
        m_idx = (m_idx == model_len(m_mode) - 1) ? 0 : m_idx + 1;
      end else m_bc++;
    end else m_pend = m_pend | inj;
  endtask

  task automatic run(input int n);
    repeat (n) step(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    m_mode = m; m_idx = 0; m_bc = 0;
    @(negedge clk);
    mode = m; bit_en = 0; inject = 0; line_flip = 0; err_clear = 0;
  endtask

  task automatic flips(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0);
      run(7);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; mode = 0; bit_en = 0; inject = 0; err_clear = 0; line_flip = 0;
    m_mode = 0; m_idx = 0; m_bc = 0; m_pend = 0; last_tx = 0;
    repeat (4) @(negedge clk);
    chk(in_sync == 0, "R7 reset sync", int'(in_sync), 0);
    chk(err_count == 0, "R9 reset count", int'(err_count), 0);
    chk(tx_bit == 0, "R5 reset tx", int'(tx_bit), 0);
    rst = 0;

    // R1 and R7: lock to the 0xFF/0x00 cycle
    run(1800);
    chk(in_sync == 1, "R7 lock mode0", int'(in_sync), 1);
    chk(err_count == 0, "R1 clean loopback", int'(err_count), 0);

    // R6: inject together with an enable, then inject without one
    step(1'b1, 1'b1, 1'b0, 1'b0);
    run(4);
    chk(err_count == 1, "R6 inject on enable", int'(err_count), 1);
    run(140);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    run(4);
    chk(err_count == 2, "R6 pending inject", int'(err_count), 2);

    // R5: sparse enables
    for (int k = 0; k < 100; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
    end
    run(140);

    // R11: clear and a counted error on the same edge
    step(1'b1, 1'b0, 1'b1, 1'b1);
    run(1);
    chk(err_count == 0, "R11 clear beats error", int'(err_count), 0);
    run(140);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    run(1);
    chk(err_count == 1, "R9 one bit error", int'(err_count), 1);
    run(140);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    run(1);
    chk(err_count == 0, "R11 plain clear", int'(err_count), 0);
    run(140);

    // R8: three errored octets keep sync, four drop it
    flips(3);
    run(16);
    chk(in_sync == 1, "R8 three bad octets", int'(in_sync), 1);
    chk(err_count == 3, "R9 three errors", int'(err_count), 3);
    run(140);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    flips(4);
    run(16);
    chk(in_sync == 0, "R8 four bad octets", int'(in_sync), 0);
    chk(err_count == 4, "R9 four errors", int'(err_count), 4);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    run(1);
    chk(err_count == 4, "R9 no count without sync", int'(err_count), 4);

    run(1800);
    chk(in_sync == 1, "R7 relock mode0", int'(in_sync), 1);

    // R9 and R2: mode change drops sync, then lock to the flag cycle
    set_mode(2'd1);
    run(1);
    chk(in_sync == 0, "R9 mode change drop", int'(in_sync), 0);
    run(1800);
    chk(in_sync == 1, "R2 lock mode1", int'(in_sync), 1);
    chk(err_count == 4, "R2 clean mode1", int'(err_count), 4);

    // R4: sparse 55-octet cycle
    set_mode(2'd3);
    run(1000);
    chk(in_sync == 1, "R4 lock mode3", int'(in_sync), 1);
    chk(err_count == 4, "R4 clean mode3", int'(err_count), 4);

    // R3 and R10: steady 0x4C, then drive the counter to saturation
    set_mode(2'd2);
    run(300);
    chk(in_sync == 1, "R3 lock mode2", int'(in_sync), 1);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    flips(3); run(140);
    flips(3); run(140);
    chk(err_count == 6, "R10 below max", int'(err_count), 6);
    flips(3); run(140);
    chk(err_count == 7, "R10 saturated", int'(err_count), 7);
    chk(in_sync == 1, "R8 spaced errors keep sync", int'(in_sync), 1);

    run(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule